// File: doc/BRIEF.md
# Display Controller Status and Interrupt Registers

This block holds the register interface of a graphics display controller. It keeps a control/status word and an interrupt mask word. Five event sources are latched as pending flags: drawing signal, drawing finish, horizontal sync, vertical sync and end of a rectangle write. A single interrupt line rises whenever a pending flag has its mask bit cleared. In the status word, writing and reading have different meanings. A write of 1 to an event bit clears and re-arms that event, while a read shows which events are pending.

The status word also carries several other fields. There is the current display field (even or odd), which flips on every vertical sync, and a field flag sampled at vertical sync. There is a two-bit FIFO condition derived from the FIFO fill level, and constant revision and identity bytes. Two write-only commands are decoded from the status word. One is a flush/suspend-drawing level, and the other is a soft reset that forces all interrupt masks on and pulses a FIFO-clear output.

Software reaches both words over a simple 64-bit register bus with separate decodes for the two addresses. Reads return data one cycle after the request.

Top module: `dispctl_csr`

## Requirements
- R1: A one-cycle pulse on `ev_pulse[i]` sets pending flag i at the next edge. A status read shows the pending flags in bits 4:0, ordered signal (bit 0), finish, hsync, vsync, rectangle-write end (bit 4).
- R2: A status write with 1 in bit i (i in 0..4) clears pending flag i, while 0 leaves it unchanged. If an event pulse and a write-1 clear hit the same flag in one cycle, the flag ends up set.
- R3: `irq_out` is 1 exactly when some pending flag i is 1 while mask bit i is 0.
- R4: A mask write stores only `bus_wdata[12:8]` as the five masks, in the same event order as R1. A mask read returns the masks in bits 12:8, ones in bits 14:13 and zero elsewhere. After reset all five masks are 1.
- R5: A status write with bit 9 set forces all five masks to 1 and pulses `fifo_clr` high for exactly one cycle after the write edge. Bit 9 reads as 0.
- R6: Each status write copies bit 8 into `flush_hold`, where 1 means flush and suspend drawing and 0 means resume. Bit 8 reads as 0.
- R7: Status bit 13 is the display field (0 even, 1 odd), which flips on each vsync pulse (`ev_pulse[3]`). Status bit 12 captures `nfield_in` on each vsync pulse. Both are 0 after reset.
- R8: Status bits 15:14 give the FIFO condition from `fifo_level`. The code is 01 when the level is 0, 10 when the level is at least `AFULL_TH` (default 56), and 00 otherwise. Code 11 is never produced, and empty wins over almost-full.
- R9: Status bits 23:16 read 0x1B and bits 31:24 read 0x55. Bits 7:5, 11:8 and 63:32 read 0. A read of any address other than the two register addresses (status at 0, mask at 1) returns 0.
- R10: `bus_rdata` updates one edge after a cycle with `bus_rd` high, carries the state as it was before that edge, and holds its value otherwise.
- R11: After reset the pending flags, `irq_out`, `flush_hold`, `fifo_clr` and `bus_rdata` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address (0 status, 1 mask) |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, one cycle after `bus_rd` |
| ev_pulse | input | 5 | Event pulses: signal, finish, hsync, vsync, rect-write end |
| nfield_in | input | 1 | Field flag captured at vsync |
| fifo_level | input | LVL_W | Current FIFO fill level |
| irq_out | output | 1 | Masked interrupt line |
| flush_hold | output | 1 | Flush and suspend-drawing level |
| fifo_clr | output | 1 | One-cycle FIFO clear from soft reset |

## Verification
The bench makes the event pulse and the write-1 clear land on the same flag in the same cycle. A design that let the clear win would lose an event and show a 0 in the pending bits. It also steps the FIFO level across 0, 1, the threshold minus one and the threshold, including an input where empty and almost-full could both apply. An encoder with the wrong priority or an off-by-one compare would return a wrong two-bit code. Mask writes with every bit set show whether stray bits leak into the mask word and whether the fixed ones at 14:13 survive. Soft resets issued while masks are cleared show whether the masks return to all ones and whether the clear pulse lasts exactly one cycle.

// File: rtl/dispctl_pkg.sv
package dispctl_pkg;
  localparam int EVT_N     = 5;
  localparam int VSYNC_IDX = 3;
  localparam int FLUSH_BIT = 8;
  localparam int SRST_BIT  = 9;
  localparam int MSK_LO    = 8;

  typedef enum logic [1:0] {
    FIFO_MID   = 2'b00,
    FIFO_EMPTY = 2'b01,
    FIFO_AFULL = 2'b10
  } fifo_code_e;
endpackage

// File: rtl/dispctl_evt_latch.sv
module dispctl_evt_latch #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_d;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // a set in the same cycle as a clear leaves the flag set
    always_comb pend_d[g] = set_i[g] | (pend_o[g] & ~clr_i[g]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o[g] <= 1'b0;
      else        pend_o[g] <= pend_d[g];
    end
  end
endmodule

// File: rtl/dispctl_fifo_stat.sv
module dispctl_fifo_stat
  import dispctl_pkg::*;
#(
  parameter int LVL_W    = 6,
  parameter int AFULL_TH = 56
) (
  input  logic [LVL_W-1:0] level_i,
  output fifo_code_e       code_o
);
  localparam logic [LVL_W-1:0] TH = LVL_W'(AFULL_TH);

  always_comb begin
    if (level_i == '0)      code_o = FIFO_EMPTY;
    else if (level_i >= TH) code_o = FIFO_AFULL;
    else                    code_o = FIFO_MID;
  end
endmodule

// File: rtl/dispctl_field_trk.sv
module dispctl_field_trk (
  input  logic clk,
  input  logic rst_n,
  input  logic vs_i,
  input  logic nfield_i,
  output logic field_o,
  output logic nfield_o
);
  logic field_d, nfield_d;

  always_comb begin
    field_d  = vs_i ? ~field_o : field_o;
    nfield_d = vs_i ? nfield_i : nfield_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_o  <= 1'b0;
      nfield_o <= 1'b0;
    end else if (vs_i) begin
      field_o  <= field_d;
      nfield_o <= nfield_d;
    end
  end
endmodule

// File: rtl/dispctl_csr.sv
module dispctl_csr
  import dispctl_pkg::*;
#(
  parameter int          ADDR_W    = 4,
  parameter int          CSR_ADDR  = 0,
  parameter int          MASK_ADDR = 1,
  parameter int          LVL_W     = 6,
  parameter int          AFULL_TH  = 56,
  parameter logic [7:0]  REV_VAL   = 8'h1B,
  parameter logic [7:0]  ID_VAL    = 8'h55
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [63:0]       bus_wdata,
  output logic [63:0]       bus_rdata,
  input  logic [EVT_N-1:0]  ev_pulse,
  input  logic              nfield_in,
  input  logic [LVL_W-1:0]  fifo_level,
  output logic              irq_out,
  output logic              flush_hold,
  output logic              fifo_clr
);
  localparam logic [ADDR_W-1:0] A_CSR = ADDR_W'(CSR_ADDR);
  localparam logic [ADDR_W-1:0] A_MSK = ADDR_W'(MASK_ADDR);

  logic             sel_csr, sel_msk, wr_csr, wr_msk, srst_cmd;
  logic [EVT_N-1:0] clr_vec, pend_q, mask_q, mask_d;
  logic             flush_d, fclr_d, field_q, nfield_q;
  fifo_code_e       fcode;
  logic [63:0]      csr_view, msk_view, rdata_d;
  logic             unused_wbits;

  assign unused_wbits = ^{bus_wdata[63:MSK_LO+EVT_N], bus_wdata[7:EVT_N]};

  always_comb begin
    sel_csr  = (bus_addr == A_CSR);
    sel_msk  = (bus_addr == A_MSK);
    wr_csr   = bus_wr & sel_csr;
    wr_msk   = bus_wr & sel_msk;
    srst_cmd = wr_csr & bus_wdata[SRST_BIT];
    clr_vec  = wr_csr ? bus_wdata[EVT_N-1:0] : '0;
  end

  dispctl_evt_latch #(.N(EVT_N)) u_evt (
    .clk(clk), .rst_n(rst_n), .set_i(ev_pulse), .clr_i(clr_vec), .pend_o(pend_q)
  );

  dispctl_fifo_stat #(.LVL_W(LVL_W), .AFULL_TH(AFULL_TH)) u_fstat (
    .level_i(fifo_level), .code_o(fcode)
  );

  dispctl_field_trk u_field (
    .clk(clk), .rst_n(rst_n), .vs_i(ev_pulse[VSYNC_IDX]), .nfield_i(nfield_in),
    .field_o(field_q), .nfield_o(nfield_q)
  );

  // next-state for mask, command outputs and read data
  always_comb begin
    if (srst_cmd)    mask_d = '1;
    else if (wr_msk) mask_d = bus_wdata[MSK_LO +: EVT_N];
    else             mask_d = mask_q;

    flush_d = wr_csr ? bus_wdata[FLUSH_BIT] : flush_hold;
    fclr_d  = srst_cmd;

    csr_view = {32'h0, ID_VAL, REV_VAL, fcode, field_q, nfield_q,
                4'h0, 3'h0, pend_q};
    msk_view = {49'h0, 2'b11, mask_q, 8'h0};

    if (sel_csr)      rdata_d = csr_view;
    else if (sel_msk) rdata_d = msk_view;
    else              rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q     <= '1;
      flush_hold <= 1'b0;
      fifo_clr   <= 1'b0;
    end else begin
      if (srst_cmd || wr_msk) mask_q <= mask_d;
      if (wr_csr) flush_hold <= flush_d;
      fifo_clr <= fclr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_d;
  end

  assign irq_out = |(pend_q & ~mask_q);
endmodule

// File: rtl/dispctl_csr_chk.sv
module dispctl_csr_chk #(
  parameter int ADDR_W    = 4,
  parameter int CSR_ADDR  = 0,
  parameter int MASK_ADDR = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [63:0]       bus_wdata,
  input logic [63:0]       bus_rdata,
  input logic [4:0]        ev_pulse,
  input logic              irq_out,
  input logic              fifo_clr,
  input logic [4:0]        pend,
  input logic [4:0]        mask,
  input logic              field
);
  logic wcsr, rcsr, rmsk;
  assign wcsr = bus_wr && (bus_addr == ADDR_W'(CSR_ADDR));
  assign rcsr = bus_rd && (bus_addr == ADDR_W'(CSR_ADDR));
  assign rmsk = bus_rd && (bus_addr == ADDR_W'(MASK_ADDR));

  p_pulse_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_pulse) |=> ((pend & $past(ev_pulse)) == $past(ev_pulse)));

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wcsr && ev_pulse == 5'h0) |=> ((pend & $past(bus_wdata[4:0])) == 5'h0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr && ev_pulse == 5'h0) |=> $stable(pend));

  p_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((pend & ~mask) != 5'h0));

  p_mask_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rmsk |=> (bus_rdata[14:13] == 2'b11 && bus_rdata[63:15] == 49'h0 && bus_rdata[7:0] == 8'h0));

  p_soft_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wcsr && bus_wdata[9]) |=> (mask == 5'h1F && fifo_clr));

  p_field_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pulse[3] |=> (field != $past(field)));

  p_fifo_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rcsr |=> (bus_rdata[15:14] != 2'b11));

  p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rcsr |=> (bus_rdata[63:32] == 32'h0 && bus_rdata[11:5] == 7'h0));

  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind dispctl_csr dispctl_csr_chk #(
  .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .MASK_ADDR(MASK_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
  .irq_out(irq_out), .fifo_clr(fifo_clr), .pend(pend_q), .mask(mask_q), .field(field_q)
);

// File: tb/dispctl_csr_bench.sv
`timescale 1ns/1ps
module dispctl_csr_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [3:0]  bus_addr;
  logic [63:0] bus_wdata, bus_rdata;
  logic [4:0]  ev_pulse;
  logic        nfield_in;
  logic [5:0]  fifo_level;
  logic        irq_out, flush_hold, fifo_clr;

  always #2.5 clk = ~clk;

  dispctl_csr u_dispctl_csr (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_pulse(ev_pulse),
    .nfield_in(nfield_in), .fifo_level(fifo_level), .irq_out(irq_out),
    .flush_hold(flush_hold), .fifo_clr(fifo_clr)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  // model state
  logic [4:0]  m_pend, m_mask;
  logic        m_flush, m_fclr, m_field, m_nf;
  logic [63:0] m_rdata;

  function automatic logic [1:0] fifo_code(input logic [5:0] lvl);
    if (lvl == 6'd0)   return 2'b01;
    if (lvl >= 6'd56)  return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic [63:0] exp_read(input logic [3:0] a, input logic [5:0] lvl);
    if (a == 4'd0)
      return {32'h0, 8'h55, 8'h1B, fifo_code(lvl), m_field, m_nf, 7'h0, m_pend};
    if (a == 4'd1)
      return {49'h0, 2'b11, m_mask, 8'h0};
    return 64'h0;
  endfunction

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic wr, input logic rd, input logic [3:0] a,
                      input logic [63:0] wd, input logic [4:0] ev,
                      input logic [5:0] lvl, input logic nf);
    logic [63:0] er;
    logic [4:0]  clrv;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
    ev_pulse = ev; fifo_level = lvl; nfield_in = nf;
    er = exp_read(a, lvl);
    @(negedge clk);
    clrv   = (wr && a == 4'd0) ? wd[4:0] : 5'h0;
    m_pend = ev | (m_pend & ~clrv);
    m_fclr = wr && a == 4'd0 && wd[9];
    if (wr && a == 4'd0) begin
      m_flush = wd[8];
      if (wd[9]) m_mask = 5'h1F;
    end
    if (wr && a == 4'd1) m_mask = wd[12:8];
    if (ev[3]) begin m_field = ~m_field; m_nf = nf; end
    if (rd) m_rdata = er;
    if (rd) begin
      if (a == 4'd0)      check("R1/R7/R8/R9/R10 status read", bus_rdata, m_rdata);
      else if (a == 4'd1) check("R4/R10 mask read", bus_rdata, m_rdata);
      else                check("R9 unmapped read", bus_rdata, m_rdata);
    end else check("R10 rdata hold", bus_rdata, m_rdata);
    check("R3 irq", {63'h0, irq_out}, {63'h0, |(m_pend & ~m_mask)});
    check("R6 flush_hold", {63'h0, flush_hold}, {63'h0, m_flush});
    check("R5 fifo_clr", {63'h0, fifo_clr}, {63'h0, m_fclr});
  endtask

  task automatic idle(); step(0, 0, 4'd0, 64'h0, 5'h0, 6'd10, 1'b0); endtask
  task automatic rd_csr(input logic [5:0] lvl); step(0, 1, 4'd0, 64'h0, 5'h0, lvl, 1'b0); endtask

  initial begin
    #1000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    ev_pulse = 0; nfield_in = 0; fifo_level = 0;
    m_pend = 0; m_mask = 5'h1F; m_flush = 0; m_fclr = 0; m_field = 0; m_nf = 0; m_rdata = 0;
    repeat (3) @(negedge clk);
    // R11: reset state at the ports
    check("R11 rdata after reset", bus_rdata, 64'h0);
    check("R11 irq after reset", {63'h0, irq_out}, 64'h0);
    check("R11 flush after reset", {63'h0, flush_hold}, 64'h0);
    check("R11 fifo_clr after reset", {63'h0, fifo_clr}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd_csr(6'd0);
    check("R11 status reset value", bus_rdata, 64'h551B_4000);
    step(0, 1, 4'd1, 64'h0, 5'h0, 6'd0, 1'b0);
    check("R4 mask reset value", bus_rdata, 64'h7F00);

    // R1/R3: unmask signal, pulse it
    step(1, 0, 4'd1, 64'h0, 5'h0, 6'd3, 1'b0);
    step(0, 0, 4'd0, 64'h0, 5'h01, 6'd3, 1'b0);
    check("R3 irq after unmasked event", {63'h0, irq_out}, 64'h1);
    // R2: clear and pulse in the same cycle -> stays set
    step(1, 0, 4'd0, 64'h1F, 5'h01, 6'd3, 1'b0);
    rd_csr(6'd3);
    check("R2 pulse beats clear", {59'h0, bus_rdata[4:0]}, 64'h1);
    // R2: write 0 leaves flag
    step(1, 0, 4'd0, 64'h0, 5'h0, 6'd3, 1'b0);
    rd_csr(6'd3);
    check("R2 write 0 no effect", {59'h0, bus_rdata[4:0]}, 64'h1);
    step(1, 0, 4'd0, 64'h1, 5'h0, 6'd3, 1'b0);
    rd_csr(6'd3);
    check("R2 write 1 clears", {59'h0, bus_rdata[4:0]}, 64'h0);
    // R4: all-ones mask write
    step(1, 0, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h0, 6'd3, 1'b0);
    step(0, 1, 4'd1, 64'h0, 5'h0, 6'd3, 1'b0);
    check("R4 all-ones mask write", bus_rdata, 64'h7F00);
    // R5: soft reset with masks cleared
    step(1, 0, 4'd1, 64'h0, 5'h0, 6'd3, 1'b0);
    step(1, 0, 4'd0, 64'h300, 5'h0, 6'd3, 1'b0);
    check("R5 clr pulse high", {63'h0, fifo_clr}, 64'h1);
    idle();
    check("R5 clr pulse one cycle", {63'h0, fifo_clr}, 64'h0);
    check("R6 flush set", {63'h0, flush_hold}, 64'h1);
    // R8: level corners
    rd_csr(6'd1);  check("R8 level 1", {62'h0, bus_rdata[15:14]}, 64'h0);
    rd_csr(6'd55); check("R8 level 55", {62'h0, bus_rdata[15:14]}, 64'h0);
    rd_csr(6'd56); check("R8 level 56", {62'h0, bus_rdata[15:14]}, 64'h2);
    rd_csr(6'd63); check("R8 level 63", {62'h0, bus_rdata[15:14]}, 64'h2);
    rd_csr(6'd0);  check("R8 level 0", {62'h0, bus_rdata[15:14]}, 64'h1);
    // R7: vsync flips field and samples flag
    step(0, 0, 4'd0, 64'h0, 5'h08, 6'd3, 1'b1);
    rd_csr(6'd3);
    check("R7 field and flag", {62'h0, bus_rdata[13:12]}, 64'h3);
    // R9: unmapped
    step(0, 1, 4'd7, 64'h0, 5'h0, 6'd3, 1'b0);
    check("R9 unmapped zero", bus_rdata, 64'h0);

    for (int i = 0; i < 4000; i++) begin
      int unsigned op = $urandom % 8;
      logic [63:0] wd = {$urandom, $urandom};
      logic [4:0]  ev = 5'($urandom) & 5'($urandom);
      logic [5:0]  lv;
      case ($urandom % 6)
        0: lv = 6'd0; 1: lv = 6'd55; 2: lv = 6'd56; default: lv = 6'($urandom);
      endcase
      if (($urandom % 8) != 0) wd[9] = 1'b0;
      case (op)
        0, 1: step(1, 0, 4'd0, wd, ev, lv, $urandom % 2 == 1);
        2:    step(1, 0, 4'd1, wd, ev, lv, $urandom % 2 == 1);
        3, 4: step(0, 1, 4'd0, 64'h0, ev, lv, $urandom % 2 == 1);
        5:    step(0, 1, 4'd1, 64'h0, ev, lv, $urandom % 2 == 1);
        6:    step(0, 1, 4'($urandom % 14 + 2), 64'h0, ev, lv, 1'b0);
        default: step(0, 0, 4'd0, 64'h0, ev, lv, $urandom % 2 == 1);
      endcase
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule